// File: doc/BRIEF.md
# Tiled Distributed RAM Array

This block is a small RAM assembled from 16-word by 1-bit storage cells. Each cell is written on the rising clock edge and read combinationally. Deeper shapes are built by decoding the upper address bits to choose which cell receives the write enable, and by multiplexing the cell outputs on read. Wider shapes are built by placing one column of cells per data bit.

A parameter selects the port arrangement. In single-port mode one address bus serves both writes and reads. In dual-port mode the storage is duplicated. Port A keeps its shared read/write address. Port B has its own address and can only read. Every port A write goes into both copies, so port B sees all the data written through port A.

The write enable is an active-high set/reset-style line, `sr_i`. An optional output register on the write clock makes both reads synchronous. The active-low `rst_ni` clears that register asynchronously and never touches the stored words.

Top module: `dram_array`

## Requirements
- R1: When `sr_i` is high at a rising edge of `clk_i`, `a_wdata_i` is stored at `a_addr_i`. When `sr_i` is low, no stored word changes.
- R2: With `OUT_REG`=0, `a_rdata_o` shows the word at `a_addr_i` in the same cycle, without waiting for a clock edge.
- R3: When a write and a combinational read use the same address, the output shows the old word before the edge and the new word after it.
- R4: In dual-port mode (`MODE`=PM_DUAL), `b_rdata_o` shows the word at `b_addr_i` and reflects every write made through port A.
- R5: In single-port mode (`MODE`=PM_SINGLE), `b_rdata_o` is held at zero.
- R6: With `DEPTH` above 16, addresses on either side of a 16-word cell boundary are distinct words: a write changes only its own address.
- R7: With `OUT_REG`=1, each read output changes one clock after its address. `rst_ni` low clears the read outputs to zero at once and leaves the stored words intact.
- R8: In dual-port mode, port B can read one address in the same cycle that port A writes another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock, also the clock of the optional output register |
| rst_ni | input | 1 | Active-low asynchronous clear of the output register |
| sr_i | input | 1 | Active-high write enable |
| a_addr_i | input | $clog2(DEPTH) | Port A read/write address |
| a_wdata_i | input | WIDTH | Port A write data |
| a_rdata_o | output | WIDTH | Port A read data |
| b_addr_i | input | $clog2(DEPTH) | Port B read-only address (dual-port mode) |
| b_rdata_o | output | WIDTH | Port B read data, zero in single-port mode |

## Verification
The bench builds two instances. The first is dual-port, 32x2, with combinational reads. Its two cell tiles per bit exercise the 15/16 boundary, port B's view of port A writes, and same-address reads around the write edge. The second is single-port, 64x2, with the output register enabled. It brings in the one-cycle read latency, a port B held at zero, four tiles per bit, and a mid-run reset that clears the outputs while the stored words survive.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic {PM_SINGLE = 1'b0, PM_DUAL = 1'b1} port_mode_e;
  localparam int unsigned CELL_WORDS = 16;
  localparam int unsigned CELL_AW    = 4;
endpackage

// File: rtl/dram_cell16.sv
module dram_cell16 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [3:0] waddr_i,
  input  logic       wdata_i,
  input  logic [3:0] raddr_i,
  output logic       rdata_o
);
  logic [15:0] mem;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

  assert_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem));
endmodule

// File: rtl/dram_bank.sv
module dram_bank #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned NCELL = DEPTH / dram_pkg::CELL_WORDS,
  localparam int unsigned SW    = (AW > dram_pkg::CELL_AW) ? AW - dram_pkg::CELL_AW : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rdata_o
);
  logic [SW-1:0]    wsel, rsel;
  logic [NCELL-1:0] cell_we, cell_rd;

  generate
    if (NCELL > 1) begin : g_sel
      assign wsel = waddr_i[AW-1:dram_pkg::CELL_AW];
      assign rsel = raddr_i[AW-1:dram_pkg::CELL_AW];
    end else begin : g_nosel
      assign wsel = '0;
      assign rsel = '0;
    end

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
      assign cell_we[c] = we_i && (wsel == SW'(c));
      dram_cell16 u_cell (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cell_we[c]),
        .waddr_i (waddr_i[3:0]),
        .wdata_i (wdata_i),
        .raddr_i (raddr_i[3:0]),
        .rdata_o (cell_rd[c])
      );
    end
  endgenerate

  // read mux over tiles
  always_comb begin
    rdata_o = 1'b0;
    for (int c = 0; c < int'(NCELL); c++) begin
      if (rsel == SW'(c)) rdata_o = cell_rd[c];
    end
  end

  assert_we_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cell_we));

  assert_we_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |-> cell_we == '0);
endmodule

// File: rtl/dram_array.sv
module dram_array #(
  parameter dram_pkg::port_mode_e MODE = dram_pkg::PM_DUAL,
  parameter int unsigned DEPTH   = 32,
  parameter int unsigned WIDTH   = 2,
  parameter bit          OUT_REG = 1'b0,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sr_i,
  input  logic [AW-1:0]    a_addr_i,
  input  logic [WIDTH-1:0] a_wdata_i,
  output logic [WIDTH-1:0] a_rdata_o,
  input  logic [AW-1:0]    b_addr_i,
  output logic [WIDTH-1:0] b_rdata_o
);
  logic [WIDTH-1:0] a_raw, b_raw;

  generate
    for (genvar w = 0; w < WIDTH; w++) begin : g_bit
      dram_bank #(.DEPTH(DEPTH)) u_bank_a (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (sr_i),
        .waddr_i (a_addr_i),
        .wdata_i (a_wdata_i[w]),
        .raddr_i (a_addr_i),
        .rdata_o (a_raw[w])
      );
      if (MODE == dram_pkg::PM_DUAL) begin : g_dual
        // mirror copy: write side follows port A
        dram_bank #(.DEPTH(DEPTH)) u_bank_b (
          .clk_i   (clk_i),
          .rst_ni  (rst_ni),
          .we_i    (sr_i),
          .waddr_i (a_addr_i),
          .wdata_i (a_wdata_i[w]),
          .raddr_i (b_addr_i),
          .rdata_o (b_raw[w])
        );
      end else begin : g_single
        assign b_raw[w] = 1'b0;
      end
    end

    if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          a_rdata_o <= '0;
          b_rdata_o <= '0;
        end else begin
          a_rdata_o <= a_raw;
          b_rdata_o <= b_raw;
        end
      end

      assert_oreg_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> a_rdata_o == $past(a_raw));
    end else begin : g_comb
      assign a_rdata_o = a_raw;
      assign b_rdata_o = b_raw;
    end

    if (MODE == dram_pkg::PM_DUAL) begin : g_chk_dual
      assert_mirror_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_addr_i == b_addr_i) |-> (a_raw == b_raw));
    end
  endgenerate
endmodule

// File: tb/dram_array_test.sv
`timescale 1ns/1ps
module dram_array_test;
  import dram_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // dual-port 32x2, combinational reads
  logic       sr = 1'b0;
  logic [4:0] a_addr = '0, b_addr = '0;
  logic [1:0] a_wd = '0, a_rd, b_rd;

  dram_array #(.MODE(PM_DUAL), .DEPTH(32), .WIDTH(2), .OUT_REG(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sr_i(sr),
    .a_addr_i(a_addr), .a_wdata_i(a_wd), .a_rdata_o(a_rd),
    .b_addr_i(b_addr), .b_rdata_o(b_rd)
  );

  // single-port 64x2, registered reads
  logic       r_sr = 1'b0;
  logic [5:0] r_a_addr = '0, r_b_addr = '0;
  logic [1:0] r_wd = '0, r_a_rd, r_b_rd;

  dram_array #(.MODE(PM_SINGLE), .DEPTH(64), .WIDTH(2), .OUT_REG(1'b1)) uut_reg (
    .clk_i(clk), .rst_ni(rst_n), .sr_i(r_sr),
    .a_addr_i(r_a_addr), .a_wdata_i(r_wd), .a_rdata_o(r_a_rd),
    .b_addr_i(r_b_addr), .b_rdata_o(r_b_rd)
  );

  function automatic logic [1:0] fill_val(int k);
    return 2'((k + k / 16) % 4);
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {we, a_addr, wdata, b_addr, exp_a, exp_b}; outputs checked before the edge
  localparam logic [16:0] VEC [9] = '{
    {1'b0, 5'd0,  2'd0, 5'd16, 2'd0, 2'd1},
    {1'b1, 5'd15, 2'd2, 5'd15, 2'd3, 2'd3},
    {1'b0, 5'd15, 2'd0, 5'd15, 2'd2, 2'd2},
    {1'b1, 5'd16, 2'd0, 5'd17, 2'd1, 2'd2},
    {1'b0, 5'd17, 2'd3, 5'd16, 2'd2, 2'd0},
    {1'b0, 5'd17, 2'd0, 5'd17, 2'd2, 2'd2},
    {1'b1, 5'd31, 2'd3, 5'd0,  2'd0, 2'd0},
    {1'b0, 5'd31, 2'd0, 5'd31, 2'd3, 2'd3},
    {1'b0, 5'd14, 2'd0, 5'd15, 2'd2, 2'd2}
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset a", r_a_rd, 2'd0);
    chk("R7 reset b", r_b_rd, 2'd0);
    rst_n = 1'b1;

    // fill dual-port array
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      sr = 1'b1; a_addr = 5'(k); a_wd = fill_val(k);
    end
    @(negedge clk);
    sr = 1'b0;

    // R1 R2 R3 R4 R6 R8 vector walk
    foreach (VEC[i]) begin
      @(negedge clk);
      {sr, a_addr, a_wd, b_addr} = VEC[i][16:4];
      #1;
      chk($sformatf("R2/R3/R6 vec%0d port A", i), a_rd, VEC[i][3:2]);
      chk($sformatf("R4/R8 vec%0d port B", i), b_rd, VEC[i][1:0]);
    end
    @(negedge clk);
    sr = 1'b0;

    // R3: new data visible right after the write edge
    a_addr = 5'd5; b_addr = 5'd5; a_wd = 2'd2; sr = 1'b1;
    #1 chk("R3 before edge", a_rd, 2'd1);
    @(posedge clk); #1;
    chk("R3 after edge", a_rd, 2'd2);
    chk("R4 after edge", b_rd, 2'd2);
    @(negedge clk);
    sr = 1'b0;

    // registered single-port instance
    r_sr = 1'b1; r_a_addr = 6'd40; r_wd = 2'd2;
    @(negedge clk);
    r_a_addr = 6'd8; r_wd = 2'd1;
    @(negedge clk);
    r_sr = 1'b0; r_wd = 2'd3;
    @(negedge clk);
    chk("R7 read 8", r_a_rd, 2'd1);
    chk("R5 port B zero", r_b_rd, 2'd0);
    r_a_addr = 6'd40; r_b_addr = 6'd40;
    #1 chk("R7 latency hold", r_a_rd, 2'd1);
    @(negedge clk);
    chk("R7 read 40", r_a_rd, 2'd2);
    chk("R5 port B zero", r_b_rd, 2'd0);
    r_a_addr = 6'd41;
    @(negedge clk);
    r_a_addr = 6'd40;
    rst_n = 1'b0;
    #1 chk("R7 async clear", r_a_rd, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 contents kept", r_a_rd, 2'd2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule